// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It decides when an embedded program or erase operation has finished. A single-cycle start pulse supplies the status address, the operation kind and, for a program, the byte that was meant to be stored. The poller then reads that address repeatedly over a simple request/acknowledge read bus. It watches a status bit that inverts on every read while the device is busy, and an error bit that the device raises on an internal fault.

The block reports completion when two consecutive reads agree on the toggle bit and no error is flagged. When a read shows the error bit, the poller always takes two more reads before it decides, because the toggle bit may have stopped in the same instant the error appeared. A successful program is followed by one extra read of the same address, which is compared against the intended byte. A cap on the number of comparison reads ends a run that never settles and reports it as a timeout failure. Sending the command sequence to the flash and deciding whether to retry are left to the surrounding logic.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `pass_o`, `fail_o`, `timeout_o` and `mismatch_o` are all 0.
- R2: A start pulse in the idle state captures `addr_i`. `rd_addr_o` shows that address for every read of the run. A start pulse that arrives while a run is in progress is ignored.
- R3: `rd_req_o` stays high until the cycle in which `rd_ack_i` is seen. It is low in the following cycle, so only one read is ever outstanding.
- R4: Bit 6 of a read is the toggle bit. The first read of a run only records bit 6. Each later read with bit 5 equal to 0 and bit 6 equal to the previous read's bit 6 ends polling with a pass.
- R5: A polling read with bit 5 equal to 1 starts a re-check of exactly two more reads. The result is pass if their bit 6 values match and fail if they differ. The poll limit does not apply to this case.
- R6: `max_polls_i` (1 or more) limits the comparison reads that follow the first read. If the last one allowed still shows bit 6 changed with bit 5 at 0, the run ends with `fail_o` and `timeout_o` at 1 and issues no further read.
- R7: When `is_prog_i` was 1 at start and polling ended in a pass, exactly one verify read follows. `mismatch_o` is 1 if and only if that byte differs from `exp_i`. An erase run (`is_prog_i` = 0) and any failed run take no verify read, and `mismatch_o` stays 0.
- R8: `done_o` is high for exactly one cycle per run. While it is high, exactly one of `pass_o` and `fail_o` is 1, and `timeout_o` is 1 only together with `fail_o`.
- R9: `pass_o`, `fail_o`, `timeout_o` and `mismatch_o` hold their values after `done_o` until the next accepted start. They read 0 in the cycle that follows that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| is_prog_i | input | 1 | 1 = program run (verify read follows), 0 = erase run |
| addr_i | input | AW | Status address to poll |
| exp_i | input | DW | Intended byte for the verify compare |
| max_polls_i | input | CW | Maximum comparison reads after the first read |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DW | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed |
| fail_o | output | 1 | Operation failed (error re-check or timeout) |
| timeout_o | output | 1 | Failure caused by the poll limit |
| mismatch_o | output | 1 | Verify byte differed from the intended byte |

## Verification
The bench builds the block with a 16-bit address, 8-bit data and a 4-bit poll-limit counter. The narrow counter lets the timeout case run with a small limit of 3 in a few cycles, and a 15-poll run reaches the counter's full-scale value. The bus responder answers each request from a per-scenario script of status bytes. The number of reads consumed therefore shows directly whether the re-check, verify and timeout paths took exactly the reads they should.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_POLL,
    ST_RC1,
    ST_RC2,
    ST_VERIFY,
    ST_FIN
  } tp_state_e;
endpackage

// File: rtl/tpoll_bus.sv
module tpoll_bus #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          rsp_vld_o,
  output logic [DW-1:0] rsp_data_o
);
  logic req_q, req_d, req_en;

  always_comb begin
    req_en = 1'b0;
    req_d  = req_q;
    if (req_q && rd_ack_i) begin
      req_en = 1'b1;
      req_d  = 1'b0;
    end else if (!req_q && go_i) begin
      req_en = 1'b1;
      req_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end

  assign rd_req_o   = req_q;
  assign rd_addr_o  = addr_i;
  assign busy_o     = req_q;
  assign rsp_vld_o  = req_q && rd_ack_i;
  assign rsp_data_o = rd_data_i;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_ack_i) |=> !rd_req_o);
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));
endmodule

// File: rtl/tpoll_cnt.sv
module tpoll_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] max_i,
  output logic          last_o
);
  localparam int EW = CW + 1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (EW'(cnt_q) + EW'(1)) >= EW'(max_i);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (max_i != '0 && !clr_i) |-> (cnt_q < max_i));
endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm
  import tpoll_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_i,
  input  logic [CW-1:0] max_polls_i,
  input  logic          busy_i,
  input  logic          rsp_vld_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          last_i,
  output logic          go_o,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] max_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic          mismatch_o
);
  tp_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [CW-1:0] max_q;
  logic          prog_q, ref_q, ref_d, ref_en, cfg_en;
  logic          pass_q, fail_q, to_q, mis_q;
  logic          pass_d, fail_d, to_d, mis_d, res_en;
  logic          tog, err, pass_ok;

  assign tog = rsp_data_i[TOG_BIT];
  assign err = rsp_data_i[ERR_BIT];
  assign pass_ok = 1'b1;

  always_comb begin
    state_d   = state_q;
    ref_d     = tog;
    ref_en    = 1'b0;
    cfg_en    = 1'b0;
    res_en    = 1'b0;
    pass_d    = pass_q;
    fail_d    = fail_q;
    to_d      = to_q;
    mis_d     = mis_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        cfg_en = 1'b1; res_en = 1'b1; cnt_clr_o = 1'b1;
        pass_d = 1'b0; fail_d = 1'b0; to_d = 1'b0; mis_d = 1'b0;
        state_d = ST_FIRST;
      end
      ST_FIRST: if (rsp_vld_i) begin
        ref_en = 1'b1; state_d = ST_POLL;
      end
      ST_POLL: if (rsp_vld_i) begin
        ref_en = 1'b1;
        if (err) state_d = ST_RC1;
        else if (tog == ref_q) begin
          res_en = 1'b1; pass_d = pass_ok;
          state_d = prog_q ? ST_VERIFY : ST_FIN;
        end else if (last_i) begin
          res_en = 1'b1; fail_d = 1'b1; to_d = 1'b1; state_d = ST_FIN;
        end else cnt_inc_o = 1'b1;
      end
      ST_RC1: if (rsp_vld_i) begin
        ref_en = 1'b1; state_d = ST_RC2;
      end
      ST_RC2: if (rsp_vld_i) begin
        res_en = 1'b1;
        if (tog == ref_q) begin
          pass_d = 1'b1; state_d = prog_q ? ST_VERIFY : ST_FIN;
        end else begin
          fail_d = 1'b1; state_d = ST_FIN;
        end
      end
      ST_VERIFY: if (rsp_vld_i) begin
        res_en = 1'b1; mis_d = (rsp_data_i != exp_q); state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= '0;
      max_q   <= '0;
      prog_q  <= 1'b0;
      ref_q   <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      to_q    <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cfg_en) begin
        addr_q <= addr_i;
        exp_q  <= exp_i;
        max_q  <= max_polls_i;
        prog_q <= is_prog_i;
      end
      if (ref_en) ref_q <= ref_d;
      if (res_en) begin
        pass_q <= pass_d;
        fail_q <= fail_d;
        to_q   <= to_d;
        mis_q  <= mis_d;
      end
    end
  end

  assign go_o = !busy_i && (state_q inside {ST_FIRST, ST_POLL, ST_RC1, ST_RC2, ST_VERIFY});
  assign addr_o     = addr_q;
  assign max_o      = max_q;
  assign done_o     = (state_q == ST_FIN);
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign timeout_o  = to_q;
  assign mismatch_o = mis_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));
  // R8
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> fail_o);
  // R7
  mismatch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> (pass_o && prog_q));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> $stable({pass_o, fail_o, timeout_o, mismatch_o}));
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic          mismatch_o
);
  logic          go, busy, rsp_vld, last, cnt_clr, cnt_inc;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] max_q;

  tpoll_fsm #(.AW(AW), .DW(DW), .CW(CW), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_prog_i(is_prog_i),
    .addr_i(addr_i), .exp_i(exp_i), .max_polls_i(max_polls_i),
    .busy_i(busy), .rsp_vld_i(rsp_vld), .rsp_data_i(rsp_data), .last_i(last),
    .go_o(go), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .addr_o(addr_q), .max_o(max_q),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o),
    .mismatch_o(mismatch_o)
  );

  tpoll_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go_i(go), .addr_i(addr_q),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy), .rsp_vld_o(rsp_vld), .rsp_data_o(rsp_data)
  );

  tpoll_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .max_i(max_q), .last_o(last)
  );
endmodule

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;
  localparam int AW = 16, DW = 8, CW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, is_prog_i = 1'b0, rd_ack_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] exp_i = '0, rd_data_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic rd_req_o, done_o, pass_o, fail_o, timeout_o, mismatch_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] scr [0:31];
  int idx = 0, errors = 0, checks = 0;
  bit addr_bad = 1'b0;
  logic [AW-1:0] cur_addr = '0;

  flash_toggle_poller #(.AW(AW), .DW(DW), .CW(CW)) u_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_prog_i(is_prog_i),
    .addr_i(addr_i), .exp_i(exp_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .mismatch_o(mismatch_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder: acknowledges each request one cycle, from the script
  initial forever begin
    @(negedge clk);
    if (rd_req_o && !rd_ack_i) begin
      if (rd_addr_o !== cur_addr) addr_bad = 1'b1;
      rd_ack_i = 1'b1;
      rd_data_i = scr[idx];
      idx++;
    end else rd_ack_i = 1'b0;
  end

  task automatic fill(input logic [DW-1:0] a, input logic [DW-1:0] b);
    for (int i = 0; i < 32; i++) scr[i] = i[0] ? b : a;
    idx = 0;
  endtask

  task automatic launch(input logic prog, input logic [AW-1:0] a,
                        input logic [DW-1:0] e, input logic [CW-1:0] m);
    @(negedge clk);
    start_i = 1'b1; is_prog_i = prog; addr_i = a; exp_i = e; max_polls_i = m;
    cur_addr = a; addr_bad = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 cleared after start", {pass_o, fail_o, timeout_o, mismatch_o}, 4'b0000);
  endtask

  task automatic finish_run(input string tag, input logic p, input logic f,
                            input logic t, input logic mm, input int nreads);
    int n = 0;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    chk({tag, " R8 done seen"}, done_o, 1'b1);
    chk({tag, " verdict"}, {pass_o, fail_o, timeout_o, mismatch_o}, {p, f, t, mm});
    chk({tag, " read count"}, idx, nreads);
    chk({tag, " R2 address"}, addr_bad, 1'b0);
    @(negedge clk);
    chk({tag, " R8 done single cycle"}, done_o, 1'b0);
    repeat (4) @(negedge clk);
    chk({tag, " R9 hold"}, {pass_o, fail_o, timeout_o, mismatch_o}, {p, f, t, mm});
    chk({tag, " no extra reads"}, idx, nreads);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {rd_req_o, done_o, pass_o, fail_o, timeout_o, mismatch_o}, 6'b0);
  endtask

  task automatic t_erase_pass();  // R4: 1,0,1,1 -> pass, no verify (R7)
    fill(8'h00, 8'h00);
    scr[0] = 8'h40; scr[1] = 8'h00; scr[2] = 8'h40; scr[3] = 8'h40;
    launch(1'b0, 16'h1234, 8'h00, 4'd8);
    finish_run("R4 erase pass", 1, 0, 0, 0, 4);
  endtask

  task automatic t_prog_match();  // R4 R7
    fill(8'h00, 8'h00);
    scr[0] = 8'h00; scr[1] = 8'h40; scr[2] = 8'h40; scr[3] = 8'hA5;
    launch(1'b1, 16'h0F0F, 8'hA5, 4'd8);
    finish_run("R7 verify match", 1, 0, 0, 0, 4);
  endtask

  task automatic t_prog_mismatch();  // R7
    fill(8'h00, 8'h00);
    scr[0] = 8'h40; scr[1] = 8'h40; scr[2] = 8'h12;
    launch(1'b1, 16'h0002, 8'h13, 4'd8);
    finish_run("R7 verify mismatch", 1, 0, 0, 1, 3);
  endtask

  task automatic t_err_fail();  // R5: recheck still toggling -> fail, no verify
    fill(8'h00, 8'h00);
    scr[0] = 8'h00; scr[1] = 8'h60; scr[2] = 8'h20; scr[3] = 8'h60;
    launch(1'b1, 16'h4444, 8'h00, 4'd8);
    finish_run("R5 recheck fail", 0, 1, 0, 0, 4);
  endtask

  task automatic t_err_pass();  // R5: recheck stopped -> pass, then verify
    fill(8'h00, 8'h00);
    scr[0] = 8'h40; scr[1] = 8'h20; scr[2] = 8'h00; scr[3] = 8'h00; scr[4] = 8'h55;
    launch(1'b1, 16'h5555, 8'h55, 4'd8);
    finish_run("R5 recheck pass", 1, 0, 0, 0, 5);
  endtask

  task automatic t_err_on_limit();  // R5: error on final allowed poll still rechecks
    fill(8'h00, 8'h40);
    scr[1] = 8'h60; scr[2] = 8'h40; scr[3] = 8'h40;
    launch(1'b0, 16'h0007, 8'h00, 4'd1);
    finish_run("R5 recheck beyond limit", 1, 0, 0, 0, 4);
  endtask

  task automatic t_timeout();  // R6: limit 3 -> first + 3 compares
    fill(8'h00, 8'h40);
    launch(1'b1, 16'h00AA, 8'h00, 4'd3);
    finish_run("R6 timeout", 0, 1, 1, 0, 4);
  endtask

  task automatic t_full_scale();  // R6: limit 15, settles on the 15th compare
    fill(8'h00, 8'h40);
    scr[15] = scr[14];
    launch(1'b0, 16'h0BAD, 8'h00, 4'd15);
    finish_run("R6 settles at limit", 1, 0, 0, 0, 16);
  endtask

  task automatic t_busy_start();  // R2: start during a run is ignored
    fill(8'h00, 8'h40);
    scr[8] = scr[7];
    launch(1'b0, 16'h3C3C, 8'h00, 4'd12);
    repeat (5) @(negedge clk);
    start_i = 1'b1; addr_i = 16'hFFFF; is_prog_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 address kept", rd_addr_o, 16'h3C3C);
    finish_run("R2 busy start", 1, 0, 0, 0, 9);
  endtask

  task automatic t_one_outstanding();  // R3: gap cycle after every ack
    int viol = 0;
    fill(8'h00, 8'h40);
    scr[6] = scr[5];
    launch(1'b0, 16'h0001, 8'h00, 4'd10);
    for (int i = 0; i < 40; i++) begin
      logic acked;
      acked = rd_ack_i;
      @(negedge clk);
      if (acked && rd_req_o) viol++;
    end
    chk("R3 request low after ack", viol, 0);
    chk("R3 reads", idx, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_erase_pass();
    t_prog_match();
    t_prog_mismatch();
    t_err_fail();
    t_err_pass();
    t_err_on_limit();
    t_timeout();
    t_full_scale();
    t_busy_start();
    t_one_outstanding();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule